// File: doc/BRIEF.md
# Phase-Accumulator Sine/Cosine Synthesizer

This block is the digital core of a direct frequency synthesizer. A 32-bit phase register advances by a programmable frequency word on every enabled clock and wraps freely. The output frequency is therefore f_clk * freq_word / 2^32. Only the twelve most significant phase bits are kept. They address a split-table converter that returns a signed 16-bit sine and a signed 16-bit cosine for the same phase, in the same cycle, together with a valid flag.

The converter splits the 12-bit phase into a 6-bit coarse angle and a 6-bit fine angle. It reads the sine and cosine of each angle from four small tables of 64 entries each. It then combines them with the angle-sum identities, using four multipliers and two adders. With 12 bits of phase, the spurious-free dynamic range is roughly 70 dB. Spurs grow when the frequency word shares a large power-of-two factor with 2^20, the range of the discarded bits. The full word is therefore taken as a plain input, and software can choose odd values.

The output stream has no back-pressure. Every accepted phase produces exactly one sample, and the consumer must take each sample in the cycle its valid flag is high. A synchronous clear returns the phase to zero and leaves the frequency word input untouched.

Top module: `dds_synth_core`

## Requirements
- R1: After reset, out_valid is 0 and sin_out and cos_out read 0. The phase register is 0, so the first enabled cycle yields sine 0 and cosine 32767.
- R2: In a cycle with en=1 and phase_clr=0, the phase register advances by freq_word. In a cycle with en=0 and phase_clr=0, it holds its value.
- R3: The phase register wraps modulo 2^32 with no flag. For example, a word of 0xC000_0000 visits phases 0, 3072/4096, 2048/4096, 1024/4096, 0 and so on.
- R4: Each sample uses only phase bits [31:20] (p = phase >> 20). The lower 20 bits affect the output only through their carries into bit 20.
- R5: For a sample of truncated phase p, sin_out lies within 3 LSB of round(32767*sin(2*pi*p/4096)), and cos_out lies within 3 LSB of round(32767*cos(2*pi*p/4096)).
- R6: At the quarter-turn points, the results are exact. p=0 gives (0, 32767), p=1024 gives (32767, 0), p=2048 gives (0, -32767), and p=3072 gives (-32767, 0), written as (sin_out, cos_out).
- R7: A sample is taken in every cycle with en=1 and phase_clr=0, using the phase value before that cycle's advance. Its result is presented with out_valid=1 exactly 3 rising edges later. Back-to-back samples come out on back-to-back cycles.
- R8: While out_valid is 0, sin_out and cos_out hold the last sample.
- R9: phase_clr=1 sets the phase register to 0 at the next edge and takes priority over en. No sample is taken in that cycle. The next enabled cycle samples phase 0.
- R10: sin_out and cos_out saturate to the range -32767 to +32767 and never show -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_word | input | 32 | Phase increment added per enabled cycle |
| en | input | 1 | Take a sample and advance the phase this cycle |
| phase_clr | input | 1 | Synchronous clear of the phase register, overrides en |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |
| out_valid | output | 1 | High for one cycle per sample, no back-pressure |

## Verification
A sample accepted at one rising edge passes through three registers: table read, products, and sum. Its result is therefore due after the third rising edge, and the phase register shows an advance or a clear after the first edge. The bench drives and samples on falling edges. Each accepted sample carries the bench's cycle stamp and its truncated phase. On every falling edge, the bench requires out_valid to be high exactly when the oldest stamp is three cycles old, and it compares the data only then. In all other cycles, it requires the outputs to hold.

// File: rtl/dds_synth_pkg.sv
package dds_synth_pkg;

  // Rounded amplitude of sin or cos at angle 2*pi*idx/2^log2n, by Taylor series
  function automatic int trig_code(input int idx, input int log2n, input real amp,
                                   input bit want_cos);
    real two_pi, x, term, acc;
    two_pi = 6.283185307179586;
    x = two_pi * real'(idx) / real'(1 << log2n);
    if (x > 3.141592653589793) x = x - two_pi;
    if (want_cos) begin
      term = 1.0;
      acc  = 1.0;
      for (int n = 1; n <= 14; n++) begin
        term = -term * x * x / real'((2 * n - 1) * (2 * n));
        acc  = acc + term;
      end
    end else begin
      term = x;
      acc  = x;
      for (int n = 1; n <= 14; n++) begin
        term = -term * x * x / real'((2 * n) * (2 * n + 1));
        acc  = acc + term;
      end
    end
    acc = acc * amp;
    if (acc >= 0.0) return $rtoi(acc + 0.5);
    return -$rtoi(0.5 - acc);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  input  logic             en,
  input  logic             clr,
  output logic [ACC_W-1:0] phase,
  output logic             fire
);
  // sample request for the converter: clear wins over enable
  assign fire = en & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (clr)  phase <= '0;
    else if (en)   phase <= phase + freq_word;
  end
endmodule

// File: rtl/dds_trig_rom.sv
module dds_trig_rom
  import dds_synth_pkg::*;
#(
  parameter int CO_W  = 6,
  parameter int FI_W  = 6,
  parameter int OUT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [CO_W+FI_W-1:0]      phase,
  output logic signed [OUT_W-1:0]   co_sin,
  output logic signed [OUT_W-1:0]   co_cos,
  output logic signed [OUT_W:0]     fi_sin,
  output logic signed [OUT_W:0]     fi_cos,
  output logic                      out_valid
);
  localparam int PH_W    = CO_W + FI_W;
  localparam int DEPTH_C = 1 << CO_W;
  localparam int DEPTH_F = 1 << FI_W;
  localparam int FINE_W  = OUT_W + 1;
  localparam real AMP_C  = real'((1 << (OUT_W - 1)) - 1);
  localparam real AMP_F  = real'(1 << (OUT_W - 1));

  logic signed [OUT_W-1:0]  c_sin_tab [DEPTH_C];
  logic signed [OUT_W-1:0]  c_cos_tab [DEPTH_C];
  logic signed [FINE_W-1:0] f_sin_tab [DEPTH_F];
  logic signed [FINE_W-1:0] f_cos_tab [DEPTH_F];

  // coarse angles span a full turn; fine angles span one coarse step
  for (genvar i = 0; i < DEPTH_C; i++) begin : g_coarse
    localparam int CS = trig_code(i, CO_W, AMP_C, 1'b0);
    localparam int CC = trig_code(i, CO_W, AMP_C, 1'b1);
    assign c_sin_tab[i] = OUT_W'(CS);
    assign c_cos_tab[i] = OUT_W'(CC);
  end

  for (genvar j = 0; j < DEPTH_F; j++) begin : g_fine
    localparam int FS = trig_code(j, PH_W, AMP_F, 1'b0);
    localparam int FC = trig_code(j, PH_W, AMP_F, 1'b1);
    assign f_sin_tab[j] = FINE_W'(FS);
    assign f_cos_tab[j] = FINE_W'(FC);
  end

  logic [CO_W-1:0] c_idx;
  logic [FI_W-1:0] f_idx;
  assign c_idx = phase[PH_W-1 -: CO_W];
  assign f_idx = phase[FI_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      co_sin    <= '0;
      co_cos    <= '0;
      fi_sin    <= '0;
      fi_cos    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        co_sin <= c_sin_tab[c_idx];
        co_cos <= c_cos_tab[c_idx];
        fi_sin <= f_sin_tab[f_idx];
        fi_cos <= f_cos_tab[f_idx];
      end
    end
  end
endmodule

// File: rtl/dds_rot_mixer.sv
module dds_rot_mixer #(
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [OUT_W-1:0] co_sin,
  input  logic signed [OUT_W-1:0] co_cos,
  input  logic signed [OUT_W:0]   fi_sin,
  input  logic signed [OUT_W:0]   fi_cos,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out,
  output logic                    out_valid
);
  localparam int FINE_W = OUT_W + 1;
  localparam int PROD_W = OUT_W + FINE_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = OUT_W - 1;
  localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1) <<< (OUT_W - 2);
  localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) <<< (OUT_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV;

  logic signed [PROD_W-1:0] p_sc, p_cs, p_cc, p_ss;
  logic                     prod_v;
  logic signed [SUM_W-1:0]  sum_s, sum_c;

  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [SUM_W-1:0] v);
    if (v > MAXV) return MAXV[OUT_W-1:0];
    if (v < MINV) return MINV[OUT_W-1:0];
    return v[OUT_W-1:0];
  endfunction

  // angle-sum identities: sin(a+b) = sa*cb + ca*sb, cos(a+b) = ca*cb - sa*sb
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_v <= 1'b0;
      p_sc   <= '0;
      p_cs   <= '0;
      p_cc   <= '0;
      p_ss   <= '0;
    end else begin
      prod_v <= in_valid;
      if (in_valid) begin
        p_sc <= co_sin * fi_cos;
        p_cs <= co_cos * fi_sin;
        p_cc <= co_cos * fi_cos;
        p_ss <= co_sin * fi_sin;
      end
    end
  end

  always_comb begin
    sum_s = (SUM_W'(p_sc) + SUM_W'(p_cs) + RND) >>> SHIFT;
    sum_c = (SUM_W'(p_cc) - SUM_W'(p_ss) + RND) >>> SHIFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sin_out   <= '0;
      cos_out   <= '0;
    end else begin
      out_valid <= prod_v;
      if (prod_v) begin
        sin_out <= clamp(sum_s);
        cos_out <= clamp(sum_c);
      end
    end
  end
endmodule

// File: rtl/dds_synth_core.sv
module dds_synth_core #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int CO_W  = 6,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        freq_word,
  input  logic                    en,
  input  logic                    phase_clr,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out,
  output logic                    out_valid
);
  localparam int FI_W   = PH_W - CO_W;
  localparam int FINE_W = OUT_W + 1;

  logic [ACC_W-1:0]         acc_phase;
  logic                     fire;
  logic [PH_W-1:0]          ph_trunc;
  logic signed [OUT_W-1:0]  co_sin, co_cos;
  logic signed [FINE_W-1:0] fi_sin, fi_cos;
  logic                     lut_v;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .en        (en),
    .clr       (phase_clr),
    .phase     (acc_phase),
    .fire      (fire)
  );

  // discard the low phase bits; only the top PH_W reach the converter
  assign ph_trunc = acc_phase[ACC_W-1 -: PH_W];

  dds_trig_rom #(.CO_W(CO_W), .FI_W(FI_W), .OUT_W(OUT_W)) u_rom (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fire),
    .phase     (ph_trunc),
    .co_sin    (co_sin),
    .co_cos    (co_cos),
    .fi_sin    (fi_sin),
    .fi_cos    (fi_cos),
    .out_valid (lut_v)
  );

  dds_rot_mixer #(.OUT_W(OUT_W)) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lut_v),
    .co_sin    (co_sin),
    .co_cos    (co_cos),
    .fi_sin    (fi_sin),
    .fi_cos    (fi_cos),
    .sin_out   (sin_out),
    .cos_out   (cos_out),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/dds_synth_checker.sv
module dds_synth_checker #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ACC_W-1:0]        freq_word,
  input logic                    en,
  input logic                    phase_clr,
  input logic [ACC_W-1:0]        acc_phase,
  input logic signed [OUT_W-1:0] sin_out,
  input logic signed [OUT_W-1:0] cos_out,
  input logic                    out_valid
);
  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  int unsigned cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= 0;
    else if (cyc < 3)  cyc <= cyc + 1;
  end

  // R2 and R3: advance by the word, modulo 2^ACC_W
  p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && $past(en && !phase_clr)) |-> acc_phase == $past(acc_phase) + $past(freq_word));

  p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && $past(!en && !phase_clr)) |-> acc_phase == $past(acc_phase));

  p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> acc_phase == '0);

  p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3) |-> out_valid == $past(en && !phase_clr, 3));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && !out_valid) |-> ($stable(sin_out) && $stable(cos_out)));

  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sin_out != MOST_NEG && cos_out != MOST_NEG));
endmodule

bind dds_synth_core dds_synth_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freq_word (freq_word),
  .en        (en),
  .phase_clr (phase_clr),
  .acc_phase (acc_phase),
  .sin_out   (sin_out),
  .cos_out   (cos_out),
  .out_valid (out_valid)
);

// File: tb/dds_synth_core_bench.sv
`timescale 1ns/1ps
module dds_synth_core_bench;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic               phase_clr = 1'b0;
  logic [31:0]        freq_word = '0;
  logic signed [15:0] sin_out, cos_out;
  logic               out_valid;

  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  logic [31:0] ph_model = '0;
  int          q_ph[$];
  int          q_cyc[$];
  int          last_sin = 0;
  int          last_cos = 0;
  string       cur_req = "R5";

  always #2 clk = ~clk;

  dds_synth_core u_dds_synth_core (
    .clk (clk), .rst_n (rst_n), .freq_word (freq_word), .en (en),
    .phase_clr (phase_clr), .sin_out (sin_out), .cos_out (cos_out),
    .out_valid (out_valid)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int ref_trig(input int p, input bit want_cos);
    real a, r;
    a = 6.283185307179586 * real'(p) / 4096.0;
    r = 32767.0 * (want_cos ? $cos(a) : $sin(a));
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(0.5 - r);
  endfunction

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic observe();
    bit due;
    int p, tol, es, ec;
    due = (q_cyc.size() > 0) && (q_cyc[0] + 3 == cyc);
    check("R7", out_valid == due, "out_valid", int'(out_valid), int'(due));
    if (due) begin
      p = q_ph.pop_front();
      void'(q_cyc.pop_front());
      if (out_valid) begin
        tol = (p % 1024 == 0) ? 0 : 3;
        es = ref_trig(p, 1'b0);
        ec = ref_trig(p, 1'b1);
        check(cur_req, absdiff(int'(sin_out), es) <= tol, $sformatf("sin p=%0d", p), int'(sin_out), es);
        check(cur_req, absdiff(int'(cos_out), ec) <= tol, $sformatf("cos p=%0d", p), int'(cos_out), ec);
        check("R10", int'(sin_out) != -32768 && int'(cos_out) != -32768, "range sin", int'(sin_out), es);
      end
    end else if (!out_valid) begin
      check("R8", int'(sin_out) == last_sin, "held sin", int'(sin_out), last_sin);
      check("R8", int'(cos_out) == last_cos, "held cos", int'(cos_out), last_cos);
    end
    last_sin = int'(sin_out);
    last_cos = int'(cos_out);
  endtask

  task automatic step(input logic e, input logic c, input logic [31:0] f);
    @(negedge clk);
    cyc++;
    observe();
    en = e;
    phase_clr = c;
    freq_word = f;
    if (c) ph_model = '0;
    else if (e) begin
      q_ph.push_back(int'(ph_model[31:20]));
      q_cyc.push_back(cyc);
      ph_model = ph_model + f;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, freq_word);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid == 1'b0, "valid after reset", int'(out_valid), 0);
    check("R1", int'(sin_out) == 0, "sin after reset", int'(sin_out), 0);
    check("R1", int'(cos_out) == 0, "cos after reset", int'(cos_out), 0);
    step(1'b1, 1'b0, 32'h0);
    drain();
  endtask

  task automatic t_quadrants();
    cur_req = "R6";
    step(1'b0, 1'b1, 32'h4000_0000);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 32'h4000_0000);
    drain();
  endtask

  task automatic t_sweep();
    cur_req = "R5";
    step(1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 32'h0123_4567);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 32'h0A5A_5A5B);
    drain();
  endtask

  task automatic t_truncation();
    cur_req = "R4";
    step(1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 32'h000F_FFFF);
    drain();
  endtask

  task automatic t_wrap();
    cur_req = "R3";
    step(1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 32'hC000_0000);
    drain();
  endtask

  task automatic t_idle();
    cur_req = "R2";
    step(1'b0, 1'b1, 32'h0);
    step(1'b1, 1'b0, 32'h0040_0000);
    step(1'b0, 1'b0, 32'h0040_0000);
    step(1'b0, 1'b0, 32'h0040_0000);
    step(1'b1, 1'b0, 32'h0040_0000);
    step(1'b1, 1'b0, 32'h0040_0000);
    step(1'b0, 1'b0, 32'h0040_0000);
    step(1'b1, 1'b0, 32'h0040_0000);
    drain();
  endtask

  task automatic t_hold();
    cur_req = "R8";
    step(1'b1, 1'b0, 32'h0155_5555);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 32'h0155_5555);
    step(1'b1, 1'b0, 32'h0155_5555);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 32'h0155_5555);
  endtask

  task automatic t_clear();
    cur_req = "R9";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'h2000_0000);
    step(1'b1, 1'b1, 32'h2000_0000);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 32'h2000_0000);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_quadrants();
    t_sweep();
    t_truncation();
    t_wrap();
    t_idle();
    t_hold();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule